// File: doc/BRIEF.md
# Per-Subcarrier Channel Estimate Accumulator

This block builds up a channel estimate for every subcarrier over a run of training symbols, taking one complex sample per clock. Each accepted sample first has its training sign pattern removed. The result is then combined with the running total held for its subcarrier. The total may be overwritten, increased by the sample or decreased by it. Running totals are 20-bit signed values per component and saturate at the ends of their range.

The totals sit in a storage array split into two regions. During a training symbol one region supplies the previous totals and the other receives the new ones. A one-cycle swap pulse between symbols exchanges the roles of the two regions. Because the read and the write never target the same region within a symbol, the read, combine and write stages run as a two-stage pipeline and a new subcarrier can enter on every clock. A separate readout port returns, by carrier index, the totals of the most recently completed region while the other region keeps accumulating.

Top module: `chanest_accum`

## Requirements
- R1: When `in_scramble` is 1 both the I and Q parts of the sample are negated before they are combined; when it is 0 they are used unchanged.
- R2: With `in_first` low, `in_sub` = 0 adds the descrambled sample to the stored total of its carrier, and `in_sub` = 1 subtracts it.
- R3: With `in_first` high, the new total ignores the stored value and becomes the descrambled sample (`in_sub` = 0) or its negation (`in_sub` = 1).
- R4: A total that would exceed 524287 is clamped to 524287, and a total below -524288 is clamped to -524288, separately for I and Q.
- R5: A sample is accepted on every clock where `in_valid` is 1, with no stall between carriers. Cycles where `in_valid` is 0 leave every stored total unchanged.
- R6: A cycle with `in_swap` = 1 exchanges the two regions. Samples, including one in the same cycle as the swap, read from the region written during the previous symbol and write to the other region.
- R7: A cycle with `rd_en` = 1 produces, on the next cycle, `rd_valid` = 1 and the I/Q totals for `rd_carrier` from the completed region (the one not being written). `rd_valid` is 0 in every other cycle. Readout runs alongside accumulation without disturbing it.
- R8: A sample or readout issued in the cycle right after a write to the same carrier and region sees the newly written total.
- R9: Reset (`rst_n` low, asynchronous) clears `rd_valid` and selects region 0 for writing and region 1 for reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present this cycle |
| in_i | input | 16 | Sample in-phase part, signed |
| in_q | input | 16 | Sample quadrature part, signed |
| in_carrier | input | 6 | Subcarrier index of the sample |
| in_scramble | input | 1 | 1 negates the sample before combining |
| in_sub | input | 1 | 0 adds, 1 subtracts |
| in_first | input | 1 | 1 overwrites the total instead of combining |
| in_swap | input | 1 | Exchange read and write regions from this cycle on |
| rd_en | input | 1 | Readout request |
| rd_carrier | input | 6 | Subcarrier index to read out |
| rd_valid | output | 1 | Readout data valid |
| rd_i | output | 20 | Read total, in-phase, signed |
| rd_q | output | 20 | Read total, quadrature, signed |

## Verification
Two functions meet in the same cycle. A readout of the completed region is issued alongside a sample, so one region is read for the host while the other is being written. A swap, a new sample and a readout are also driven together right after a write to the same carrier, and the forwarding path must then return the in-flight total. Both cases come up as whole symbols run back to back with a readout every cycle, and as chains of one-sample symbols that swap on every clock. Each returned total is compared with a reference model of the two regions kept in the bench.

// File: rtl/chanest_pkg.sv
package chanest_pkg;
   // default geometry of the accumulator
   localparam int DEF_DATA_W   = 16;
   localparam int DEF_ACC_W    = 20;
   localparam int DEF_CARRIERS = 64;

   // number of components in one complex word (I at index 0, Q at index 1)
   localparam int NCOMP = 2;

   typedef enum logic {
      OP_ADD = 1'b0,
      OP_SUB = 1'b1
   } comb_op_e;
endpackage

// File: rtl/chanest_descramble.sv
module chanest_descramble
   import chanest_pkg::*;
#(
   parameter int DATA_W = DEF_DATA_W,
   parameter int ACC_W  = DEF_ACC_W
) (
   input  logic [DATA_W-1:0]            smp_i,
   input  logic [DATA_W-1:0]            smp_q,
   input  logic                         flip,
   output logic [NCOMP-1:0][ACC_W-1:0]  ext_o
);
   localparam int PAD_W = ACC_W - DATA_W;

   logic [NCOMP-1:0][DATA_W-1:0] raw;
   assign raw[0] = smp_i;
   assign raw[1] = smp_q;

   for (genvar k = 0; k < NCOMP; k++) begin : g_comp
      logic [ACC_W-1:0] widened;
      // sign-extend first so the most negative input negates without wrap
      assign widened  = {{PAD_W{raw[k][DATA_W-1]}}, raw[k]};
      assign ext_o[k] = flip ? (ACC_W'(0) - widened) : widened;
   end
endmodule

// File: rtl/chanest_addsat.sv
module chanest_addsat
   import chanest_pkg::*;
#(
   parameter int ACC_W    = DEF_ACC_W,
   parameter bit SATURATE = 1'b1
) (
   input  logic [NCOMP-1:0][ACC_W-1:0] old_v,
   input  logic [NCOMP-1:0][ACC_W-1:0] x_v,
   input  comb_op_e                    op,
   input  logic                        first,
   output logic [NCOMP-1:0][ACC_W-1:0] res_v
);
   localparam logic signed [ACC_W:0] MAX_V = {2'b00, {(ACC_W-1){1'b1}}};
   localparam logic signed [ACC_W:0] MIN_V = {2'b11, {(ACC_W-1){1'b0}}};

   for (genvar k = 0; k < NCOMP; k++) begin : g_comp
      logic signed [ACC_W:0] o_e;
      logic signed [ACC_W:0] x_e;
      logic signed [ACC_W:0] wide;

      assign o_e = $signed({old_v[k][ACC_W-1], old_v[k]});
      assign x_e = $signed({x_v[k][ACC_W-1], x_v[k]});

      always_comb begin
         if (first) begin
            wide = (op == OP_SUB) ? -x_e : x_e;
         end else begin
            wide = (op == OP_SUB) ? (o_e - x_e) : (o_e + x_e);
         end
      end

      if (SATURATE) begin : g_sat
         always_comb begin
            if (wide > MAX_V) begin
               res_v[k] = MAX_V[ACC_W-1:0];
            end else if (wide < MIN_V) begin
               res_v[k] = MIN_V[ACC_W-1:0];
            end else begin
               res_v[k] = wide[ACC_W-1:0];
            end
         end
      end else begin : g_wrap
         assign res_v[k] = wide[ACC_W-1:0];
      end
   end
endmodule

// File: rtl/chanest_bankram.sv
module chanest_bankram #(
   parameter int WORD_W = 40,
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              ra_en,
   input  logic [ADDR_W-1:0] ra_addr,
   output logic [WORD_W-1:0] ra_data,
   input  logic              rb_en,
   input  logic [ADDR_W-1:0] rb_addr,
   output logic [WORD_W-1:0] rb_data
);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int NREAD  = 2;

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   logic [NREAD-1:0]             rd_req;
   logic [NREAD-1:0][ADDR_W-1:0] rd_addr;
   assign rd_req  = {rb_en, ra_en};
   assign rd_addr = {rb_addr, ra_addr};

   // synchronous read ports; a write landing on the same edge is forwarded
   for (genvar p = 0; p < NREAD; p++) begin : g_rd
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk) begin
         if (rd_req[p]) begin
            q <= (wr_en && (wr_addr == rd_addr[p])) ? wr_data : mem[rd_addr[p]];
         end
      end
   end

   assign ra_data = g_rd[0].q;
   assign rb_data = g_rd[1].q;
endmodule

// File: rtl/chanest_accum.sv
module chanest_accum
   import chanest_pkg::*;
#(
   parameter int DATA_W   = DEF_DATA_W,
   parameter int ACC_W    = DEF_ACC_W,
   parameter int CARRIERS = DEF_CARRIERS,
   parameter bit SATURATE = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic signed [DATA_W-1:0]      in_i,
   input  logic signed [DATA_W-1:0]      in_q,
   input  logic [$clog2(CARRIERS)-1:0]   in_carrier,
   input  logic                          in_scramble,
   input  logic                          in_sub,
   input  logic                          in_first,
   input  logic                          in_swap,
   input  logic                          rd_en,
   input  logic [$clog2(CARRIERS)-1:0]   rd_carrier,
   output logic                          rd_valid,
   output logic signed [ACC_W-1:0]       rd_i,
   output logic signed [ACC_W-1:0]       rd_q
);
   localparam int CIDX_W = $clog2(CARRIERS);
   localparam int ADDR_W = CIDX_W + 1;
   localparam int WORD_W = NCOMP * ACC_W;

   if (ACC_W <= DATA_W) begin : g_bad_acc
      $error("chanest_accum: ACC_W must exceed DATA_W");
   end
   if (CARRIERS < 2) begin : g_bad_carr
      $error("chanest_accum: CARRIERS must be at least 2");
   end

   // ---------------- region selection ----------------
   logic wbank;
   logic eff_wbank;
   assign eff_wbank = wbank ^ in_swap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbank <= 1'b0;
      end else begin
         wbank <= eff_wbank;
      end
   end

   // ---------------- stage 0: descramble, issue read ----------------
   logic [NCOMP-1:0][ACC_W-1:0] x0;

   chanest_descramble #(
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W)
   ) u_desc (
      .smp_i (in_i),
      .smp_q (in_q),
      .flip  (in_scramble),
      .ext_o (x0)
   );

   // ---------------- stage 1 registers ----------------
   logic                        s1_valid;
   logic [NCOMP-1:0][ACC_W-1:0] s1_x;
   comb_op_e                    s1_op;
   logic                        s1_first;
   logic [ADDR_W-1:0]           s1_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
      end else begin
         s1_valid <= in_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         s1_x     <= x0;
         s1_op    <= comb_op_e'(in_sub);
         s1_first <= in_first;
         s1_addr  <= {eff_wbank, in_carrier};
      end
   end

   // ---------------- storage ----------------
   logic                  wr_en;
   logic [WORD_W-1:0]     wr_word;
   logic [WORD_W-1:0]     old_word;
   logic [WORD_W-1:0]     out_word;
   logic [NCOMP-1:0][ACC_W-1:0] new_v;

   assign wr_en   = s1_valid;
   assign wr_word = new_v;

   chanest_bankram #(
      .WORD_W (WORD_W),
      .ADDR_W (ADDR_W)
   ) u_ram (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (s1_addr),
      .wr_data (wr_word),
      .ra_en   (in_valid),
      .ra_addr ({~eff_wbank, in_carrier}),
      .ra_data (old_word),
      .rb_en   (rd_en),
      .rb_addr ({~eff_wbank, rd_carrier}),
      .rb_data (out_word)
   );

   // ---------------- stage 1: combine and saturate ----------------
   chanest_addsat #(
      .ACC_W    (ACC_W),
      .SATURATE (SATURATE)
   ) u_comb (
      .old_v (old_word),
      .x_v   (s1_x),
      .op    (s1_op),
      .first (s1_first),
      .res_v (new_v)
   );

   // ---------------- readout ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
      end
   end

   assign rd_i = $signed(out_word[ACC_W-1:0]);
   assign rd_q = $signed(out_word[WORD_W-1:ACC_W]);
endmodule

// File: rtl/chanest_accum_chk.sv
module chanest_accum_chk #(
   parameter int DATA_W = 16,
   parameter int ACC_W  = 20,
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_i,
   input logic              in_scramble,
   input logic              in_sub,
   input logic              in_first,
   input logic              in_swap,
   input logic              rd_en,
   input logic              rd_valid,
   input logic              wbank,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [ACC_W-1:0]  wr_i
);
   localparam int PAD_W = ACC_W - DATA_W;

   assert_rdvalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   assert_rdidle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);
   assert_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_swap |=> (wbank != $past(wbank)));
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_swap |=> $stable(wbank));
   assert_wrbank_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (wr_addr[ADDR_W-1] == wbank));
   assert_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> wr_en);
   assert_noaccept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !wr_en);
   assert_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_first && !in_sub && !in_scramble) |=>
         (wr_i == {{PAD_W{$past(in_i[DATA_W-1])}}, $past(in_i)}));
   assert_flip_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_first && !in_sub && in_scramble) |=>
         (wr_i == ACC_W'(0) - {{PAD_W{$past(in_i[DATA_W-1])}}, $past(in_i)}));
endmodule

bind chanest_accum chanest_accum_chk #(
   .DATA_W (DATA_W),
   .ACC_W  (ACC_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_i        (in_i),
   .in_scramble (in_scramble),
   .in_sub      (in_sub),
   .in_first    (in_first),
   .in_swap     (in_swap),
   .rd_en       (rd_en),
   .rd_valid    (rd_valid),
   .wbank       (wbank),
   .wr_en       (wr_en),
   .wr_addr     (s1_addr),
   .wr_i        (wr_word[ACC_W-1:0])
);

// File: tb/sim_chanest_accum.sv
`timescale 1ns/1ps
module sim_chanest_accum;
   localparam int NC    = 64;
   localparam int MAXA  = 524287;
   localparam int MINA  = -524288;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               in_valid, in_scramble, in_sub, in_first, in_swap, rd_en;
   logic signed [15:0] in_i, in_q;
   logic [5:0]         in_carrier, rd_carrier;
   logic               rd_valid;
   logic signed [19:0] rd_i, rd_q;

   always #4 clk = ~clk;

   chanest_accum u0 (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_i (in_i), .in_q (in_q),
      .in_carrier (in_carrier), .in_scramble (in_scramble), .in_sub (in_sub),
      .in_first (in_first), .in_swap (in_swap), .rd_en (rd_en),
      .rd_carrier (rd_carrier), .rd_valid (rd_valid), .rd_i (rd_i), .rd_q (rd_q)
   );

   int    checks = 0;
   int    errors = 0;
   bit    done   = 1'b0;
   int    wb     = 0;
   int    acc_i [2][NC];
   int    acc_q [2][NC];
   int    exp_i [$];
   int    exp_q [$];
   string exp_t [$];

   function automatic int sat(input int v);
      if (v > MAXA) return MAXA;
      if (v < MINA) return MINA;
      return v;
   endfunction

   // driver: one clock of stimulus; the reference model is updated and
   // any readout expectation is pushed for the monitor
   task automatic step(input bit v, input int i, input int q, input int c,
                       input bit scr, input bit sub, input bit first, input bit swp,
                       input bit rd, input int rc, input string tag);
      int xi, xq, rb;
      in_valid = v; in_i = 16'(i); in_q = 16'(q); in_carrier = 6'(c);
      in_scramble = scr; in_sub = sub; in_first = first; in_swap = swp;
      rd_en = rd; rd_carrier = 6'(rc);
      if (swp) wb = 1 - wb;
      rb = 1 - wb;
      if (v) begin
         xi = scr ? -i : i;
         xq = scr ? -q : q;
         if (first) begin
            acc_i[wb][c] = sub ? -xi : xi;
            acc_q[wb][c] = sub ? -xq : xq;
         end else begin
            acc_i[wb][c] = sat(sub ? acc_i[rb][c] - xi : acc_i[rb][c] + xi);
            acc_q[wb][c] = sat(sub ? acc_q[rb][c] - xq : acc_q[rb][c] + xq);
         end
      end
      if (rd) begin
         exp_i.push_back(acc_i[rb][rc]);
         exp_q.push_back(acc_q[rb][rc]);
         exp_t.push_back(tag);
      end
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
   endtask

   // monitor: pops expectations as readout data appears
   always @(negedge clk) begin
      if (rst_n === 1'b1 && rd_valid === 1'b1) begin
         checks++;
         if (exp_i.size() == 0) begin
            errors++;
            $display("FAIL R7 unexpected rd_valid actual=1 expected=0");
         end else begin
            int ei, eq;
            string t;
            ei = exp_i.pop_front();
            eq = exp_q.pop_front();
            t  = exp_t.pop_front();
            if (int'(rd_i) != ei || int'(rd_q) != eq) begin
               errors++;
               $display("FAIL %s readout actual=(%0d,%0d) expected=(%0d,%0d)",
                        t, rd_i, rd_q, ei, eq);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R5 watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      in_valid = 0; in_i = 0; in_q = 0; in_carrier = 0; in_scramble = 0;
      in_sub = 0; in_first = 0; in_swap = 0; rd_en = 0; rd_carrier = 0;
      repeat (3) @(negedge clk);
      checks++;
      if (rd_valid !== 1'b0) begin
         errors++;
         $display("FAIL R9 rd_valid in reset actual=%b expected=0", rd_valid);
      end
      rst_n = 1'b1;
      idle(2);
      checks++;
      if (rd_valid !== 1'b0) begin
         errors++;
         $display("FAIL R9 rd_valid after reset actual=%b expected=0", rd_valid);
      end

      // symbol A: overwrite every carrier (R3), swap with first sample (R6)
      for (int c = 0; c < NC; c++)
         step(1, c*411 - 13000, 9000 - c*277, c, (c % 3) == 0, (c % 5) == 0, 1,
              c == 0, 0, 0, "R3");
      // symbol B: accumulate, while reading A's totals every cycle (R7)
      for (int c = 0; c < NC; c++)
         step(1, (c*733) % 20000 - 9000, 4000 - c*151, c, (c % 2) == 1, (c % 4) == 1, 0,
              c == 0, 1, NC - 1 - c, "R7");
      // symbol C: accumulate, while reading B's totals (R1 scrambled, R2 plain)
      for (int c = 0; c < NC; c++)
         step(1, c*97 - 3000, -(c*53), c, (c % 3) == 2, (c % 2) == 0, 0,
              c == 0, 1, c, ((c % 2) == 1) ? "R1" : "R2");
      // close C and read it back-to-back (R5)
      step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "");
      for (int c = 0; c < NC; c++) step(0, 0, 0, 0, 0, 0, 0, 0, 1, c, "R5");
      idle(2);

      // positive saturation: one-sample symbols swapping every clock (R4, R8)
      for (int k = 0; k < 20; k++) step(1, 32767, -32768, 7, 0, 0, k == 0, 1, 0, 0, "");
      step(0, 0, 0, 0, 0, 0, 0, 1, 1, 7, "R4");
      // negative saturation through scramble plus subtract (R4, R1)
      for (int k = 0; k < 20; k++) step(1, -32768, 32767, 8, 1, 1, k == 0, 1, 0, 0, "");
      step(0, 0, 0, 0, 0, 0, 0, 1, 1, 8, "R4");
      idle(2);

      // forwarding: readout right after the write to the same location (R8)
      step(1, 1234, -4321, 9, 0, 0, 1, 1, 0, 0, "");
      step(0, 0, 0, 0, 0, 0, 0, 1, 1, 9, "R8");
      step(1, 500, 600, 10, 0, 0, 1, 1, 0, 0, "");
      step(1, 70, -80, 10, 0, 1, 0, 1, 0, 0, "");
      step(0, 0, 0, 0, 0, 0, 0, 1, 1, 10, "R8");
      idle(2);

      // valid low with busy data must not touch the write region (R5)
      for (int k = 0; k < 5; k++) step(0, 30000, -30000, 9 + (k % 2), 1, 1, 1, 0, 0, 0, "");
      step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "");
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 9, "R5");
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 10, "R5");
      idle(3);

      checks++;
      if (exp_i.size() != 0) begin
         errors++;
         $display("FAIL R7 missing readouts actual=%0d expected=0", exp_i.size());
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule